// File: doc/BRIEF.md
# Bit-Plane Pass Classifier

This block walks one bit-plane of a small code-block of coefficient magnitudes and decides, for every bit, which of the three coding passes codes it: significance propagation, magnitude refinement or clean-up. The magnitudes are written into an internal coefficient store through a simple write port. A start pulse then launches a walk of the chosen plane. The block emits one record per bit, giving its column, row, pass, bit value and whether the record is the first refinement of that coefficient. The records leave on a valid/ready stream. When the last record has been accepted, a done flag rises.

The block keeps three kinds of state. A significance flag and a refinement-applied flag belong to each coefficient and persist from plane to plane. A visited-in-first-pass flag belongs to each bit position and lives for one plane only. Significance changes during the walk, so the fixed visiting order decides which pass codes a bit. That order is stripes four rows tall, column by column inside a stripe, top to bottom inside a column. A caller codes a block by pulsing start once per plane, from the most significant plane down to plane 0. It asserts `new_blk` with the first plane of each new block.

Top module: `bitplane_pass_sorter`

## Requirements
- R1: Within each pass, positions are visited and records emitted in stripe order. A stripe is four rows (the last may be shorter) and stripes are taken top to bottom. Inside a stripe the columns are taken left to right, and the rows of a column top to bottom.
- R2: A plane is walked three times, in the order significance propagation (`rec_pass`=1), refinement (`rec_pass`=2), clean-up (`rec_pass`=3). Every one of the BLK_W*BLK_H bits yields exactly one record, and code 0 never appears.
- R3: In the first pass, a bit is coded when its coefficient is not significant and at least one of its eight neighbours is significant at the moment of the visit. Positions outside the block count as not significant, with no wrap across rows or columns.
- R4: A coefficient becomes significant right after a 1 bit of it is coded in the first or the clean-up pass. Later visits in the same walk see the new value, so significance propagates along the scan.
- R5: In the refinement pass, a bit is coded when its coefficient is significant and the bit was not coded in this plane's first pass. `rec_first_ref` is 1 only on the first refinement record a coefficient ever gets in the block, and 0 on all other records.
- R6: The clean-up pass codes every bit whose coefficient is not significant and that was not coded in the first pass.
- R7: Start with `new_blk`=1 clears all significance and refinement flags. Start with `new_blk`=0 keeps them from the previous plane. The per-bit visited flags are cleared on every start.
- R8: While `rec_valid` is high and `rec_ready` is low, the record fields hold steady. No record is lost or duplicated under back-pressure.
- R9: With `rec_ready` held high, `done` rises 3*BLK_W*BLK_H+1 clock edges after the edge that samples start. It then stays high until the next start. A start pulse during a walk is ignored.
- R10: After reset, `rec_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one coefficient magnitude |
| wr_x | input | XW | Column of the written coefficient |
| wr_y | input | YW | Row of the written coefficient |
| wr_mag | input | MAG_W | Magnitude value |
| start | input | 1 | Begin walking one plane (taken when idle or done) |
| new_blk | input | 1 | With start: clear block-level flags |
| plane | input | PW | Bit-plane index to walk |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts record |
| rec_x | output | XW | Column of the record |
| rec_y | output | YW | Row of the record |
| rec_pass | output | 2 | 1 first pass, 2 refinement, 3 clean-up |
| rec_bit | output | 1 | Value of the bit in the plane |
| rec_first_ref | output | 1 | First refinement of this coefficient |
| done | output | 1 | Plane finished and stream drained |

## Verification
The block visits one position per clock. A coded position's record shows on the ports one edge after its visit, and `done` follows one edge after the final visit once the stream has drained. The bench drives on falling edges and samples on falling edges. On each falling edge it decides the ready value for the next rising edge, and it logs a record only when that value and `rec_valid` are both high. This makes the stream comparison independent of timing. The `done` latency is checked as an exact edge count only when ready stays high, which is the case R9 defines. Under back-pressure the bench instead checks field stability on every stalled cycle.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [1:0] {
    PASS_NONE = 2'd0,
    PASS_SIG  = 2'd1,
    PASS_REF  = 2'd2,
    PASS_CLN  = 2'd3
  } pass_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FIN,
    ST_DONE
  } state_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bps_coef_store.sv
module bps_coef_store #(
  parameter int N     = 64,
  parameter int MAG_W = 8,
  parameter int AW    = 6,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [MAG_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [PW-1:0]    rd_plane,
  output logic             rd_bit
);

  // Distributed-RAM style array: synchronous write, asynchronous read.
  logic [MAG_W-1:0] mem_q [N];
  logic [MAG_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_word = mem_q[rd_addr];
  assign rd_bit  = rd_word[rd_plane];

endmodule

// File: rtl/bps_nbr_sig.sv
module bps_nbr_sig #(
  parameter int BLK_W = 8,
  parameter int BLK_H = 8,
  localparam int N    = BLK_W * BLK_H
) (
  input  logic [N-1:0] sig,
  output logic [N-1:0] nbr_any
);

  // For every cell, OR the significance of its in-block neighbours.
  for (genvar gy = 0; gy < BLK_H; gy++) begin : g_row
    for (genvar gx = 0; gx < BLK_W; gx++) begin : g_col
      logic [8:0] term;
      for (genvar k = 0; k < 9; k++) begin : g_nb
        localparam int NX = gx + (k % 3) - 1;
        localparam int NY = gy + (k / 3) - 1;
        if (k != 4 && NX >= 0 && NX < BLK_W && NY >= 0 && NY < BLK_H) begin : g_in
          assign term[k] = sig[NY*BLK_W + NX];
        end else begin : g_out
          assign term[k] = 1'b0;
        end
      end
      assign nbr_any[gy*BLK_W + gx] = |term;
    end
  end

endmodule

// File: rtl/bps_scan_walker.sv
module bps_scan_walker import bps_pkg::*; #(
  parameter int BLK_W = 8,
  parameter int BLK_H = 8,
  parameter int XW    = 3,
  parameter int YW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y,
  output pass_t         pass,
  output logic          last
);

  logic [XW-1:0] x_q;
  logic [YW-1:0] sb_q;
  logic [1:0]    r_q;
  pass_t         pass_q;
  logic          row_end, col_end, stripe_end;

  assign pos_x      = x_q;
  assign pos_y      = sb_q + YW'(r_q);
  assign pass       = pass_q;
  assign row_end    = (r_q == 2'd3) || (int'(pos_y) == BLK_H - 1);
  assign col_end    = (int'(x_q) == BLK_W - 1);
  assign stripe_end = (int'(sb_q) + 4 >= BLK_H);
  assign last       = row_end && col_end && stripe_end && (pass_q == PASS_CLN);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      x_q    <= '0;
      sb_q   <= '0;
      r_q    <= '0;
      pass_q <= PASS_SIG;
    end else if (step) begin
      if (!row_end) begin
        r_q <= r_q + 2'd1;
      end else begin
        r_q <= '0;
        if (!col_end) begin
          x_q <= x_q + XW'(1);
        end else begin
          x_q <= '0;
          if (!stripe_end) begin
            sb_q <= sb_q + YW'(4);
          end else begin
            sb_q <= '0;
            case (pass_q)
              PASS_SIG: pass_q <= PASS_REF;
              PASS_REF: pass_q <= PASS_CLN;
              default:  pass_q <= PASS_SIG;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/bitplane_pass_sorter.sv
module bitplane_pass_sorter import bps_pkg::*; #(
  parameter int  BLK_W = 8,
  parameter int  BLK_H = 8,
  parameter int  MAG_W = 8,
  localparam int XW    = idx_w(BLK_W),
  localparam int YW    = idx_w(BLK_H),
  localparam int PW    = idx_w(MAG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [XW-1:0]    wr_x,
  input  logic [YW-1:0]    wr_y,
  input  logic [MAG_W-1:0] wr_mag,
  input  logic             start,
  input  logic             new_blk,
  input  logic [PW-1:0]    plane,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [XW-1:0]    rec_x,
  output logic [YW-1:0]    rec_y,
  output logic [1:0]       rec_pass,
  output logic             rec_bit,
  output logic             rec_first_ref,
  output logic             done
);

  localparam int N  = BLK_W * BLK_H;
  localparam int AW = idx_w(N);

  state_t          st_q;
  logic [N-1:0]    sig_q, refd_q, visit_q;
  logic [N-1:0]    nbr_any;
  logic [PW-1:0]   plane_q;
  logic [XW-1:0]   cur_x;
  logic [YW-1:0]   cur_y;
  pass_t           cur_pass;
  logic            walk_last, cur_bit, coded, slot_free, walk_step, walk_restart;
  logic [AW-1:0]   cur_idx, wr_addr;

  assign slot_free    = !rec_valid || rec_ready;
  assign walk_step    = (st_q == ST_SCAN) && slot_free;
  assign walk_restart = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign cur_idx      = AW'(int'(cur_y) * BLK_W + int'(cur_x));
  assign wr_addr      = AW'(int'(wr_y) * BLK_W + int'(wr_x));

  bps_coef_store #(.N(N), .MAG_W(MAG_W), .AW(AW), .PW(PW)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_mag),
    .rd_addr  (cur_idx),
    .rd_plane (plane_q),
    .rd_bit   (cur_bit)
  );

  bps_nbr_sig #(.BLK_W(BLK_W), .BLK_H(BLK_H)) u_nbr (
    .sig     (sig_q),
    .nbr_any (nbr_any)
  );

  bps_scan_walker #(.BLK_W(BLK_W), .BLK_H(BLK_H), .XW(XW), .YW(YW)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .restart (walk_restart),
    .step    (walk_step),
    .pos_x   (cur_x),
    .pos_y   (cur_y),
    .pass    (cur_pass),
    .last    (walk_last)
  );

  // Pass membership of the position under visit.
  always_comb begin
    case (cur_pass)
      PASS_SIG: coded = !sig_q[cur_idx] && nbr_any[cur_idx];
      PASS_REF: coded =  sig_q[cur_idx] && !visit_q[cur_idx];
      PASS_CLN: coded = !sig_q[cur_idx] && !visit_q[cur_idx];
      default:  coded = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      sig_q         <= '0;
      refd_q        <= '0;
      visit_q       <= '0;
      plane_q       <= '0;
      rec_valid     <= 1'b0;
      rec_x         <= '0;
      rec_y         <= '0;
      rec_pass      <= 2'd0;
      rec_bit       <= 1'b0;
      rec_first_ref <= 1'b0;
      done          <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            visit_q <= '0;
            if (new_blk) begin
              sig_q  <= '0;
              refd_q <= '0;
            end
            plane_q <= plane;
            done    <= 1'b0;
            st_q    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (slot_free) begin
            rec_valid <= coded;
            if (coded) begin
              rec_x         <= cur_x;
              rec_y         <= cur_y;
              rec_pass      <= cur_pass;
              rec_bit       <= cur_bit;
              rec_first_ref <= (cur_pass == PASS_REF) && !refd_q[cur_idx];
              case (cur_pass)
                PASS_SIG: begin
                  visit_q[cur_idx] <= 1'b1;
                  if (cur_bit) sig_q[cur_idx] <= 1'b1;
                end
                PASS_REF: refd_q[cur_idx] <= 1'b1;
                PASS_CLN: if (cur_bit) sig_q[cur_idx] <= 1'b1;
                default: ;
              endcase
            end
            if (walk_last) st_q <= ST_FIN;
          end
        end
        default: begin
          if (slot_free) begin
            rec_valid <= 1'b0;
            done      <= 1'b1;
            st_q      <= ST_DONE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [XW-1:0] rec_x,
  input logic [YW-1:0] rec_y,
  input logic [1:0]    rec_pass,
  input logic          rec_bit,
  input logic          rec_first_ref,
  input logic          done
);

  logic [1:0] last_pass_q;

  always_ff @(posedge clk) begin
    if (rst || done) last_pass_q <= 2'd0;
    else if (rec_valid && rec_ready) last_pass_q <= rec_pass;
  end

  // R8: stalled record holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_x) && $stable(rec_y)
      && $stable(rec_pass) && $stable(rec_bit) && $stable(rec_first_ref));

  // R2: pass code never zero on a valid record
  p_pass_code_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_pass != 2'd0);

  // R2: passes never go backwards inside one plane
  p_pass_order_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_pass >= last_pass_q);

  // R5: first-refinement mark only on refinement records
  p_first_ref_r5: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_first_ref |-> rec_pass == 2'd2);

  // R9: stream is drained while done is high
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !rec_valid);

  // R9: done stays up until a new start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

endmodule

bind bitplane_pass_sorter bps_checker #(.XW(XW), .YW(YW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .rec_valid     (rec_valid),
  .rec_ready     (rec_ready),
  .rec_x         (rec_x),
  .rec_y         (rec_y),
  .rec_pass      (rec_pass),
  .rec_bit       (rec_bit),
  .rec_first_ref (rec_first_ref),
  .done          (done)
);

// File: tb/bitplane_pass_sorter_tb.sv
`timescale 1ns/1ps
module bitplane_pass_sorter_tb;

  localparam int W = 8, H = 8, MW = 8, N = W * H;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, start = 1'b0, new_blk = 1'b0, rec_ready = 1'b1;
  logic [2:0] wr_x = '0, wr_y = '0, plane = '0;
  logic [7:0] wr_mag = '0;
  logic rec_valid, rec_bit, rec_first_ref, done;
  logic [2:0] rec_x, rec_y;
  logic [1:0] rec_pass;

  always #2.5 clk = ~clk;

  bitplane_pass_sorter #(.BLK_W(W), .BLK_H(H), .MAG_W(MW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_mag(wr_mag),
    .start(start), .new_blk(new_blk), .plane(plane), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_x(rec_x), .rec_y(rec_y), .rec_pass(rec_pass),
    .rec_bit(rec_bit), .rec_first_ref(rec_first_ref), .done(done));

  int n_chk = 0, n_bad = 0;
  logic [7:0] mag [N];
  bit m_sig [N], m_ref [N], m_vis [N];
  int e_x [N], e_y [N], e_p [N], e_b [N], e_f [N];
  int g_x [N], g_y [N], g_p [N], g_b [N], g_f [N];
  int e_n, g_n, run_cyc;
  logic [15:0] lfsr = 16'hACE1;

  // {pattern, plane, new_blk, ready_mode, start_poke}
  localparam logic [8:0] VEC [12] = '{
    {3'd1, 3'd7, 1'b1, 1'b0, 1'b0}, {3'd1, 3'd6, 1'b0, 1'b0, 1'b0},
    {3'd1, 3'd5, 1'b0, 1'b1, 1'b0}, {3'd1, 3'd4, 1'b0, 1'b0, 1'b1},
    {3'd2, 3'd7, 1'b1, 1'b0, 1'b0}, {3'd2, 3'd6, 1'b0, 1'b1, 1'b0},
    {3'd2, 3'd3, 1'b0, 1'b0, 1'b0}, {3'd3, 3'd7, 1'b1, 1'b0, 1'b1},
    {3'd3, 3'd5, 1'b0, 1'b0, 1'b0}, {3'd3, 3'd2, 1'b0, 1'b1, 1'b0},
    {3'd3, 3'd0, 1'b0, 1'b0, 1'b0}, {3'd0, 3'd7, 1'b1, 1'b0, 1'b0}};

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat_mag(input int p, input int x, input int y);
    case (p)
      1: return 8'(((x * 29 + y * 53 + 7) * 13) & 255);
      2: return (x == y) ? 8'h90 : (((x + y) & 1) ? 8'h21 : 8'h04);
      3: return 8'h01 << ((x + y) & 7);
      default: return 8'h00;
    endcase
  endfunction

  task automatic load_mag();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_x = 3'(i % W); wr_y = 3'(i / W); wr_mag = mag[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit m_nbr(input int x, input int y);
    bit any = 1'b0;
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if ((dx != 0 || dy != 0) && x + dx >= 0 && x + dx < W && y + dy >= 0 && y + dy < H)
          any |= m_sig[(y + dy) * W + x + dx];
    return any;
  endfunction

  // Sequential model of the requirements R1..R7.
  task automatic model_plane(input int pl, input bit nb);
    e_n = 0;
    for (int i = 0; i < N; i++) begin
      m_vis[i] = 1'b0;
      if (nb) begin m_sig[i] = 1'b0; m_ref[i] = 1'b0; end
    end
    for (int ps = 1; ps <= 3; ps++)
      for (int sb = 0; sb < H; sb += 4)
        for (int x = 0; x < W; x++)
          for (int r = 0; r < 4 && sb + r < H; r++) begin
            int y = sb + r;
            int i = y * W + x;
            bit b = mag[i][pl];
            bit c = (ps == 1) ? (!m_sig[i] && m_nbr(x, y)) :
                    (ps == 2) ? (m_sig[i] && !m_vis[i]) : (!m_sig[i] && !m_vis[i]);
            if (c) begin
              e_x[e_n] = x; e_y[e_n] = y; e_p[e_n] = ps; e_b[e_n] = b;
              e_f[e_n] = (ps == 2 && !m_ref[i]) ? 1 : 0;
              e_n++;
              if (ps == 1) m_vis[i] = 1'b1;
              if (ps == 2) m_ref[i] = 1'b1;
              if (ps != 2 && b) m_sig[i] = 1'b1;
            end
          end
  endtask

  task automatic run_plane(input int pl, input bit nb, input bit rdy_mode, input bit poke);
    bit stalled = 1'b0;
    int sx = 0, sy = 0, sp = 0, sbit = 0, sf = 0;
    @(negedge clk);
    plane = 3'(pl); new_blk = nb; start = 1'b1; rec_ready = 1'b1;
    @(negedge clk);
    start = 1'b0; run_cyc = 0; g_n = 0;
    while (!done && run_cyc < 3000) begin
      if (stalled)  // R8: held record
        check(rec_valid && rec_x == 3'(sx) && rec_y == 3'(sy) && rec_pass == 2'(sp)
              && rec_bit == 1'(sbit) && rec_first_ref == 1'(sf), "R8 hold",
              {rec_x, rec_y, rec_pass}, {3'(sx), 3'(sy), 2'(sp)});
      if (rdy_mode) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rec_ready = lfsr[0] | lfsr[5];
      end else rec_ready = 1'b1;
      start = (poke && run_cyc == 40);
      if (poke && run_cyc == 40) begin plane = 3'(pl ^ 1); new_blk = 1'b1; end
      stalled = rec_valid && !rec_ready;
      sx = int'(rec_x); sy = int'(rec_y); sp = int'(rec_pass);
      sbit = int'(rec_bit); sf = int'(rec_first_ref);
      if (rec_valid && rec_ready) begin
        if (g_n < N) begin
          g_x[g_n] = sx; g_y[g_n] = sy; g_p[g_n] = sp; g_b[g_n] = sbit; g_f[g_n] = sf;
        end
        g_n++;
      end
      @(negedge clk);
      run_cyc++;
    end
    start = 1'b0;
    if (!done) check(1'b0, "R9 plane never finished", run_cyc, 3 * N + 1);
  endtask

  task automatic compare(input bit rdy_mode);
    check(g_n == e_n && e_n == N, "R2 record count", g_n, N);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      int a = (g_x[i] << 12) | (g_y[i] << 8) | (g_p[i] << 4) | (g_b[i] << 1) | g_f[i];
      int e = (e_x[i] << 12) | (e_y[i] << 8) | (e_p[i] << 4) | (e_b[i] << 1) | e_f[i];
      string tag = (e_p[i] == 1) ? "R3/R4 record" : (e_p[i] == 2) ? "R5 record" : "R6 record";
      check(a == e, {tag, " in R1 order"}, a, e);
    end
    if (!rdy_mode) check(run_cyc == 3 * N + 1, "R9 done latency", run_cyc, 3 * N + 1);
  endtask

  task automatic do_plane(input int pl, input bit nb, input bit rdy_mode, input bit poke);
    model_plane(pl, nb);
    run_plane(pl, nb, rdy_mode, poke);
    compare(rdy_mode);
  endtask

  function automatic int cnt(input int ps, input int want_f);
    int c = 0;
    for (int i = 0; i < g_n && i < N; i++)
      if (g_p[i] == ps && (want_f < 0 || g_f[i] == want_f)) c++;
    return c;
  endfunction

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rec_valid, "R10 rec_valid after reset", int'(rec_valid), 0);
    check(!done, "R10 done after reset", int'(done), 0);

    for (int v = 0; v < 12; v++) begin
      logic [8:0] t = VEC[v];
      if (t[2]) begin
        for (int i = 0; i < N; i++) mag[i] = pat_mag(int'(t[8:6]), i % W, i / W);
        load_mag();
      end
      do_plane(int'(t[5:3]), t[2], t[1], t[0]);
    end

    // Propagation down a column (R4) and refinement marks (R5).
    for (int i = 0; i < N; i++) mag[i] = 8'h00;
    mag[0] = 8'h80; mag[8] = 8'h40; mag[16] = 8'h40; mag[24] = 8'h40;
    load_mag();
    do_plane(7, 1'b1, 1'b0, 1'b0);
    check(cnt(3, -1) == N, "R6 all clean-up on first plane", cnt(3, -1), N);
    check(g_x[0] == 0 && g_y[0] == 0 && g_b[0] == 1, "R1 first record (0,0)", g_y[0], 0);
    do_plane(6, 1'b0, 1'b0, 1'b0);
    check(g_p[0] == 1 && g_x[0] == 0 && g_y[0] == 1 && g_b[0] == 1,
          "R4 first record (0,1) first pass", (g_p[0] << 4) | g_y[0], 16 + 1);
    check(cnt(1, -1) == 9, "R4 propagated first-pass count", cnt(1, -1), 9);
    check(cnt(2, 1) == 1, "R5 first refinement count", cnt(2, 1), 1);
    do_plane(5, 1'b0, 1'b0, 1'b0);
    check(cnt(1, -1) == 6, "R3 first-pass count", cnt(1, -1), 6);
    check(cnt(2, 1) == 3, "R5 first refinements plane 5", cnt(2, 1), 3);
    do_plane(7, 1'b0, 1'b0, 1'b0);
    check(cnt(2, -1) == 4 && cnt(2, 1) == 0, "R7 flags kept without new_blk", cnt(2, 1), 0);
    do_plane(5, 1'b1, 1'b0, 1'b0);
    check(cnt(3, -1) == N, "R7 flags cleared by new_blk", cnt(3, -1), N);

    // Corner coefficient: no wrap of neighbours (R3).
    for (int i = 0; i < N; i++) mag[i] = 8'h00;
    mag[N - 1] = 8'h80;
    load_mag();
    do_plane(7, 1'b1, 1'b0, 1'b0);
    do_plane(6, 1'b0, 1'b0, 1'b0);
    check(cnt(1, -1) == 3, "R3 corner neighbours only", cnt(1, -1), 3);

    repeat (3) @(negedge clk);
    check(done, "R9 done held while idle", int'(done), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule